// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps the wall-clock time and the calendar for a chip that already generates a one-second strobe. Each accepted strobe moves the seconds forward. When a field wraps, the carry ripples on into minutes and hours, then into the weekday and the date, then into the month, the year within the century, and finally the century. Every field is kept as one byte. A global encoding pin chooses packed decimal digits (BCD) or plain binary for all fields together, and a global format pin chooses 24-hour or 12-hour hours. In 12-hour form the top bit of the hour byte flags the afternoon.

Software loads the fields one byte at a time through a register write port and reads them back through a combinational read port. A freeze pin holds every field so that a multi-byte snapshot can be written or read without tearing. An update-in-progress flag warns software that a commit is about to happen. The flag rises the cycle after a strobe is accepted and stays high for a fixed number of cycles. The fields change at the clock edge where the flag falls. Stored bytes are never converted when the encoding or format pin changes, so software rewrites the fields after a mode change. The write port has no back-pressure: every write is taken in the cycle it is presented.

Top module: `caltime_counter`

## Requirements
- R1: Seconds and minutes count 0 to 59. On a commit, seconds step by one, and a value of 59 or more wraps to 0 and carries into minutes. Minutes behave the same way and carry into hours.
- R2: With the 24-hour pin set, the hour counts 0 to 23. A value of 23 or more wraps to 0 and gives the day carry.
- R3: With the 24-hour pin clear, the hour counts 1 to 12, and bit 7 of the hour byte is 1 for PM and 0 for AM. The step from 11 to 12 flips bit 7. The step from 12 to 1 keeps bit 7 and gives no day carry. The only 12-hour step that gives a day carry is 11 PM to 12 AM.
- R4: Encoding pin 0 means BCD, with the high digit in bits 7:4 and the low digit in bits 3:0. Encoding pin 1 means binary. Changing the pin leaves the stored bytes untouched, and the next commit reads them in the new encoding.
- R5: The weekday counts 1 to 7 and steps on the day carry. A value of 7 or more returns to 1.
- R6: The date counts 1 up to the length of the current month: 30 for months 4, 6, 9 and 11; 31 for the other months except February; and for February, 29 when the two-digit year is a multiple of 4 and 28 otherwise. Past the month length, the date returns to 1 and carries into the month.
- R7: The month counts 1 to 12 and carries into the year. The year counts 0 to 99, and its wrap from 99 to 0 advances the century, which also counts 0 to 99.
- R8: While the freeze pin is 1, strobes are not accepted, a pending commit is cancelled, and no field changes except through a write.
- R9: An accepted strobe raises the update-in-progress flag on the next cycle. The flag stays high for UIP_CYC cycles, and the fields change at the edge where it falls. The flag is 0 whenever the freeze pin is 1. The flag also reads as bit 7 of offset 0x0A, whose other bits are 0.
- R10: Register offsets are: 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 weekday, 0x07 date, 0x08 month, 0x09 year and 0x0B century. A write stores the raw byte at the next edge. A write that lands in the commit cycle wins over the commit for its own field, while the other fields still advance. Writes to any other offset are ignored, and reading any other offset returns 0.
- R11: Reset sets seconds, minutes, hours, year and century to 0x00, and weekday, date and month to 0x01.
- R12: A strobe that arrives while an update is pending is dropped. It neither restarts nor extends the pending update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| freeze_i | input | 1 | Holds all fields and cancels a pending update |
| bin_mode_i | input | 1 | 0 = BCD fields, 1 = binary fields |
| hr24_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write offset |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | ADDR_W | Read offset |
| rd_data_o | output | 8 | Byte at rd_addr_i, combinational |
| uip_o | output | 1 | Update-in-progress flag |

## Verification
The two functions that can fall in the same cycle are a software write and the tick-driven commit. A second pair is the freeze pin and a commit that is already pending. The bench times a minute write to land exactly in the commit cycle. It then expects the written byte in minutes while seconds still advance by one. Separately, the bench raises freeze while the flag is high and expects no field to move and the flag to read 0. A behavioural calendar model, updated on every edge, judges the read port and the flag on every cycle alongside these targeted checks.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  typedef logic [7:0] fld_t;

  localparam logic [3:0] OFS_SEC  = 4'h0;
  localparam logic [3:0] OFS_MIN  = 4'h2;
  localparam logic [3:0] OFS_HOUR = 4'h4;
  localparam logic [3:0] OFS_DOW  = 4'h6;
  localparam logic [3:0] OFS_DOM  = 4'h7;
  localparam logic [3:0] OFS_MON  = 4'h8;
  localparam logic [3:0] OFS_YEAR = 4'h9;
  localparam logic [3:0] OFS_STAT = 4'hA;
  localparam logic [3:0] OFS_CENT = 4'hB;

  // stored byte -> plain number under the selected encoding
  function automatic logic [7:0] fld_dec(input fld_t v, input logic bin);
    logic [7:0] t;
    t = ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    return bin ? v : t;
  endfunction

  // plain number (0..99) -> stored byte under the selected encoding
  function automatic fld_t fld_enc(input logic [7:0] n, input logic bin);
    logic [3:0] q;
    logic [3:0] r;
    q = 4'(n / 8'd10);
    r = 4'(n % 8'd10);
    return bin ? n : {q, r};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] len;
    case (mon)
      8'd2:                    len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: len = 8'd30;
      default:                 len = 8'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/caltime_wrap_step.sv
module caltime_wrap_step
  import caltime_pkg::*;
#(
  parameter int LO = 0
) (
  input  fld_t       cur,
  input  logic [7:0] top,
  input  logic       bin,
  input  logic       inc,
  output fld_t       nxt,
  output logic       carry
);
  logic [7:0] val;

  always_comb begin
    val   = fld_dec(cur, bin);
    nxt   = cur;
    carry = 1'b0;
    if (inc) begin
      if (val >= top) begin
        nxt   = fld_enc(8'(LO), bin);
        carry = 1'b1;
      end else begin
        nxt = fld_enc(val + 8'd1, bin);
      end
    end
  end
endmodule

// File: rtl/caltime_hour_step.sv
module caltime_hour_step
  import caltime_pkg::*;
(
  input  fld_t cur,
  input  logic bin,
  input  logic h24,
  input  logic inc,
  output fld_t nxt,
  output logic day_carry
);
  logic [7:0] hv;
  logic       pm;

  always_comb begin
    pm        = cur[7];
    hv        = fld_dec(h24 ? cur : {1'b0, cur[6:0]}, bin);
    nxt       = cur;
    day_carry = 1'b0;
    if (inc) begin
      if (h24) begin
        if (hv >= 8'd23) begin
          nxt       = fld_enc(8'd0, bin);
          day_carry = 1'b1;
        end else begin
          nxt = fld_enc(hv + 8'd1, bin);
        end
      end else if (hv == 8'd11) begin
        nxt       = {~pm, 7'(fld_enc(8'd12, bin))};
        day_carry = pm;
      end else if (hv >= 8'd12) begin
        nxt = {pm, 7'(fld_enc(8'd1, bin))};
      end else begin
        nxt = {pm, 7'(fld_enc(hv + 8'd1, bin))};
      end
    end
  end
endmodule

// File: rtl/caltime_uip_seq.sv
module caltime_uip_seq #(
  parameter int UIP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic freeze,
  output logic uip,
  output logic commit
);
  localparam int CW = (UIP_CYC > 1) ? $clog2(UIP_CYC) : 1;
  localparam int RW = CW + 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [RW-1:0] run;

  assign uip    = busy && !freeze;
  assign commit = busy && !freeze && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (freeze || cnt == '0) busy <= 1'b0;
      else                     cnt  <= cnt - 1'b1;
    end else if (tick && !freeze) begin
      busy <= 1'b1;
      cnt  <= CW'(UIP_CYC - 1);
    end
  end

  // length of the current busy run, for the window check below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_uip_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> run == RW'(UIP_CYC - 1));
  p_uip_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !uip);
  p_uip_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick) && !$past(freeze));
  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !freeze && cnt != '0) |=> busy && cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/caltime_counter.sv
module caltime_counter
  import caltime_pkg::*;
#(
  parameter int UIP_CYC = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              freeze_i,
  input  logic              bin_mode_i,
  input  logic              hr24_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              uip_o
);
  localparam int NLO = 2;  // seconds, minutes
  localparam int NHI = 2;  // year, century

  logic commit;
  fld_t lo_q  [NLO];
  fld_t lo_nx [NLO];
  logic lo_c  [NLO+1];
  fld_t hi_q  [NHI];
  fld_t hi_nx [NHI];
  logic hi_c  [NHI+1];
  fld_t hour_q, hour_nx;
  fld_t dow_q, dow_nx;
  fld_t dom_q, dom_nx;
  fld_t mon_q, mon_nx;
  logic day_c, dow_c, dom_c;
  logic [7:0] dom_top;

  caltime_uip_seq #(.UIP_CYC(UIP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .freeze(freeze_i),
    .uip(uip_o), .commit(commit)
  );

  assign lo_c[0] = commit;

  for (genvar i = 0; i < NLO; i++) begin : g_lo
    caltime_wrap_step #(.LO(0)) u_step (
      .cur(lo_q[i]), .top(8'd59), .bin(bin_mode_i), .inc(lo_c[i]),
      .nxt(lo_nx[i]), .carry(lo_c[i+1])
    );
  end

  caltime_hour_step u_hour (
    .cur(hour_q), .bin(bin_mode_i), .h24(hr24_i), .inc(lo_c[NLO]),
    .nxt(hour_nx), .day_carry(day_c)
  );

  caltime_wrap_step #(.LO(1)) u_dow (
    .cur(dow_q), .top(8'd7), .bin(bin_mode_i), .inc(day_c),
    .nxt(dow_nx), .carry(dow_c)
  );

  assign dom_top = month_len(fld_dec(mon_q, bin_mode_i), fld_dec(hi_q[0], bin_mode_i));

  caltime_wrap_step #(.LO(1)) u_dom (
    .cur(dom_q), .top(dom_top), .bin(bin_mode_i), .inc(day_c),
    .nxt(dom_nx), .carry(dom_c)
  );

  caltime_wrap_step #(.LO(1)) u_mon (
    .cur(mon_q), .top(8'd12), .bin(bin_mode_i), .inc(dom_c),
    .nxt(mon_nx), .carry(hi_c[0])
  );

  for (genvar j = 0; j < NHI; j++) begin : g_hi
    caltime_wrap_step #(.LO(0)) u_step (
      .cur(hi_q[j]), .top(8'd99), .bin(bin_mode_i), .inc(hi_c[j]),
      .nxt(hi_nx[j]), .carry(hi_c[j+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLO; i++) lo_q[i] <= '0;
      for (int j = 0; j < NHI; j++) hi_q[j] <= '0;
      hour_q <= '0;
      dow_q  <= 8'd1;
      dom_q  <= 8'd1;
      mon_q  <= 8'd1;
    end else begin
      if (commit) begin
        for (int i = 0; i < NLO; i++) lo_q[i] <= lo_nx[i];
        for (int j = 0; j < NHI; j++) hi_q[j] <= hi_nx[j];
        hour_q <= hour_nx;
        dow_q  <= dow_nx;
        dom_q  <= dom_nx;
        mon_q  <= mon_nx;
      end
      // a write in the commit cycle overrides the commit for its field
      if (wr_en_i) begin
        case (wr_addr_i)
          ADDR_W'(OFS_SEC):  lo_q[0] <= wr_data_i;
          ADDR_W'(OFS_MIN):  lo_q[1] <= wr_data_i;
          ADDR_W'(OFS_HOUR): hour_q  <= wr_data_i;
          ADDR_W'(OFS_DOW):  dow_q   <= wr_data_i;
          ADDR_W'(OFS_DOM):  dom_q   <= wr_data_i;
          ADDR_W'(OFS_MON):  mon_q   <= wr_data_i;
          ADDR_W'(OFS_YEAR): hi_q[0] <= wr_data_i;
          ADDR_W'(OFS_CENT): hi_q[1] <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_W'(OFS_SEC):  rd_data_o = lo_q[0];
      ADDR_W'(OFS_MIN):  rd_data_o = lo_q[1];
      ADDR_W'(OFS_HOUR): rd_data_o = hour_q;
      ADDR_W'(OFS_DOW):  rd_data_o = dow_q;
      ADDR_W'(OFS_DOM):  rd_data_o = dom_q;
      ADDR_W'(OFS_MON):  rd_data_o = mon_q;
      ADDR_W'(OFS_YEAR): rd_data_o = hi_q[0];
      ADDR_W'(OFS_CENT): rd_data_o = hi_q[1];
      ADDR_W'(OFS_STAT): rd_data_o = {uip_o, 7'd0};
      default:           rd_data_o = 8'd0;
    endcase
  end

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !wr_en_i) |=> $stable(lo_q[0]) && $stable(lo_q[1]) && $stable(hour_q)
                               && $stable(dom_q) && $stable(mon_q) && $stable(hi_q[1]));
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADDR_W'(OFS_MIN)) |=> lo_q[1] == $past(wr_data_i));
  p_sec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_en_i && fld_dec(lo_q[0], bin_mode_i) <= 8'd59)
      |=> fld_dec(lo_q[0], $past(bin_mode_i)) <= 8'd59);
  p_hour_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_en_i && hr24_i && fld_dec(hour_q, bin_mode_i) <= 8'd23)
      |=> fld_dec(hour_q, $past(bin_mode_i)) <= 8'd23);
  p_day_from_pm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hr24_i && day_c) |-> hour_q[7]);
  p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_c && !wr_en_i) |=> dow_q == 8'd1);
  p_cent_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_c[NHI] && !wr_en_i) |=> hi_q[1] == 8'd0);
endmodule

// File: tb/caltime_counter_test.sv
module caltime_counter_test;
  localparam int UIP = 4;
  localparam logic [3:0] A_SEC = 4'h0, A_MIN = 4'h2, A_HR = 4'h4, A_DOW = 4'h6,
                         A_DOM = 4'h7, A_MON = 4'h8, A_YR = 4'h9, A_ST = 4'hA, A_CEN = 4'hB;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, freeze_i = 1'b0;
  logic bin_i = 1'b0, h24_i = 1'b1, wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0, rd_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic uip;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  caltime_counter #(.UIP_CYC(UIP), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
    .bin_mode_i(bin_i), .hr24_i(h24_i), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .uip_o(uip)
  );

  always #2 clk = ~clk;  // 4 ns period

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr, m_cen;
  bit m_busy;
  int m_cnt;

  function automatic int vdec(logic [7:0] v, bit b);
    return b ? int'(v) : int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] venc(int n, bit b);
    return b ? 8'(n) : {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic advance();
    bit b = bin_i;
    int s, mi, h, dw, dm, mo, y, c, len;
    bit pm, cy;
    s = vdec(m_sec, b); mi = vdec(m_min, b);
    dw = vdec(m_dow, b); dm = vdec(m_dom, b); mo = vdec(m_mon, b);
    y = vdec(m_yr, b); c = vdec(m_cen, b);
    cy = 1'b0;
    if (s >= 59) begin s = 0; cy = 1'b1; end else s = s + 1;
    m_sec = venc(s, b);
    if (!cy) return;
    cy = 1'b0;
    if (mi >= 59) begin mi = 0; cy = 1'b1; end else mi = mi + 1;
    m_min = venc(mi, b);
    if (!cy) return;
    cy = 1'b0;
    if (h24_i) begin
      h = vdec(m_hr, b);
      if (h >= 23) begin h = 0; cy = 1'b1; end else h = h + 1;
      m_hr = venc(h, b);
    end else begin
      h = vdec({1'b0, m_hr[6:0]}, b);
      pm = m_hr[7];
      if (h == 11) begin cy = pm; pm = !pm; h = 12; end
      else if (h >= 12) h = 1;
      else h = h + 1;
      m_hr = {pm, 7'(venc(h, b))};
    end
    if (!cy) return;
    if (dw >= 7) dw = 1; else dw = dw + 1;
    m_dow = venc(dw, b);
    if (mo == 2) len = (y % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) len = 30;
    else len = 31;
    if (dm >= len) begin dm = 1; cy = 1'b1; end else begin dm = dm + 1; cy = 1'b0; end
    m_dom = venc(dm, b);
    if (!cy) return;
    if (mo >= 12) begin mo = 1; cy = 1'b1; end else begin mo = mo + 1; cy = 1'b0; end
    m_mon = venc(mo, b);
    if (!cy) return;
    if (y >= 99) begin y = 0; cy = 1'b1; end else begin y = y + 1; cy = 1'b0; end
    m_yr = venc(y, b);
    if (!cy) return;
    if (c >= 99) c = 0; else c = c + 1;
    m_cen = venc(c, b);
  endtask

  always @(posedge clk) begin
    bit do_commit;
    if (!rst_n) begin
      m_sec = 8'h00; m_min = 8'h00; m_hr = 8'h00; m_dow = 8'h01;
      m_dom = 8'h01; m_mon = 8'h01; m_yr = 8'h00; m_cen = 8'h00;
      m_busy = 1'b0; m_cnt = 0;
    end else begin
      do_commit = 1'b0;
      if (m_busy) begin
        if (freeze_i) m_busy = 1'b0;
        else if (m_cnt == 0) begin do_commit = 1'b1; m_busy = 1'b0; end
        else m_cnt = m_cnt - 1;
      end else if (tick_i && !freeze_i) begin
        m_busy = 1'b1; m_cnt = UIP - 1;
      end
      if (do_commit) advance();
      if (wr_en) begin
        case (wr_addr)
          A_SEC: m_sec = wr_data;  A_MIN: m_min = wr_data;  A_HR:  m_hr  = wr_data;
          A_DOW: m_dow = wr_data;  A_DOM: m_dom = wr_data;  A_MON: m_mon = wr_data;
          A_YR:  m_yr  = wr_data;  A_CEN: m_cen = wr_data;  default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_read(logic [3:0] a);
    case (a)
      A_SEC: return m_sec;  A_MIN: return m_min;  A_HR:  return m_hr;
      A_DOW: return m_dow;  A_DOM: return m_dom;  A_MON: return m_mon;
      A_YR:  return m_yr;   A_CEN: return m_cen;
      A_ST:  return {m_busy && !freeze_i, 7'd0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      A_SEC, A_MIN: return "R1";
      A_HR:  return "R2";
      A_DOW: return "R5";
      A_DOM: return "R6";
      A_MON, A_YR, A_CEN: return "R7";
      A_ST:  return "R9";
      default: return "R10";
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== exp_read(rd_addr)) begin
        errors++;
        $display("FAIL %s cycle read @%0h: got %02h expected %02h",
                 tag_of(rd_addr), rd_addr, rd_data, exp_read(rd_addr));
      end
      checks++;
      if (uip !== (m_busy && !freeze_i)) begin
        errors++;
        $display("FAIL R9 cycle flag: got %0b expected %0b", uip, m_busy && !freeze_i);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R9 watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      step();
      rd_addr = 4'(i % 12);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(); wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(); wr_en = 1'b0;
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                         logic [7:0] dm, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
    wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h); wr(A_DOW, dw);
    wr(A_DOM, dm); wr(A_MON, mo); wr(A_YR, y); wr(A_CEN, c);
  endtask

  task automatic pulse();
    step(); tick_i = 1'b1;
    step(); tick_i = 1'b0;
  endtask

  task automatic tick_wait();
    pulse();
    idle(UIP + 2);
  endtask

  task automatic chk(logic [3:0] a, logic [7:0] e, string tag);
    step(); rd_addr = a;
    @(negedge clk);
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s read @%0h: got %02h expected %02h", tag, a, rd_data, e);
    end
  endtask

  task automatic chk_flag(logic e, string tag);
    @(negedge clk);
    checks++;
    if (uip !== e) begin
      errors++;
      $display("FAIL %s flag: got %0b expected %0b", tag, uip, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    chk(A_SEC, 8'h00, "R11"); chk(A_HR, 8'h00, "R11"); chk(A_DOW, 8'h01, "R11");
    chk(A_DOM, 8'h01, "R11"); chk(A_MON, 8'h01, "R11"); chk(A_CEN, 8'h00, "R11");

    // binary, 24-hour: full rollover into a new century
    step(); bin_i = 1'b1; h24_i = 1'b1;
    set_all(8'h3A, 8'h3B, 8'h17, 8'h07, 8'h1F, 8'h0C, 8'h63, 8'h14);
    tick_wait();
    chk(A_SEC, 8'h3B, "R1");
    tick_wait();
    chk(A_SEC, 8'h00, "R1"); chk(A_MIN, 8'h00, "R1"); chk(A_HR, 8'h00, "R2");
    chk(A_DOW, 8'h01, "R5"); chk(A_DOM, 8'h01, "R6"); chk(A_MON, 8'h01, "R7");
    chk(A_YR, 8'h00, "R7");  chk(A_CEN, 8'h15, "R7");

    // BCD, 24-hour: 30-day month end
    step(); bin_i = 1'b0;
    set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h25, 8'h20);
    tick_wait();
    chk(A_HR, 8'h00, "R2"); chk(A_DOW, 8'h04, "R5");
    chk(A_DOM, 8'h01, "R6"); chk(A_MON, 8'h05, "R6");

    // February in leap and common years
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h24, 8'h20);
    tick_wait();
    chk(A_DOM, 8'h29, "R6"); chk(A_MON, 8'h02, "R6");
    set_all(8'h59, 8'h59, 8'h23, 8'h06, 8'h29, 8'h02, 8'h24, 8'h20);
    tick_wait();
    chk(A_DOM, 8'h01, "R6"); chk(A_MON, 8'h03, "R6");
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23, 8'h20);
    tick_wait();
    chk(A_DOM, 8'h01, "R6"); chk(A_MON, 8'h03, "R6");

    // BCD, 12-hour steps
    step(); h24_i = 1'b0;
    set_all(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h06, 8'h24, 8'h20);
    tick_wait();
    chk(A_HR, 8'h92, "R3"); chk(A_DOM, 8'h10, "R3"); chk(A_DOW, 8'h02, "R3");
    set_all(8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h06, 8'h24, 8'h20);
    tick_wait();
    chk(A_HR, 8'h81, "R3"); chk(A_DOM, 8'h10, "R3");
    set_all(8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h06, 8'h24, 8'h20);
    tick_wait();
    chk(A_HR, 8'h12, "R3"); chk(A_DOM, 8'h11, "R3"); chk(A_DOW, 8'h03, "R3");
    set_all(8'h59, 8'h59, 8'h12, 8'h02, 8'h10, 8'h06, 8'h24, 8'h20);
    tick_wait();
    chk(A_HR, 8'h01, "R3"); chk(A_DOM, 8'h10, "R3");

    // binary, 12-hour: 11 PM into a new month
    step(); bin_i = 1'b1;
    set_all(8'h3B, 8'h3B, 8'h8B, 8'h07, 8'h1E, 8'h0B, 8'h05, 8'h14);
    tick_wait();
    chk(A_HR, 8'h0C, "R3"); chk(A_DOW, 8'h01, "R5");
    chk(A_DOM, 8'h01, "R6"); chk(A_MON, 8'h0C, "R7");

    // R4: no conversion on mode change; next commit uses new encoding
    step(); bin_i = 1'b0; h24_i = 1'b1;
    wr(A_SEC, 8'h19);
    step(); bin_i = 1'b1;
    chk(A_SEC, 8'h19, "R4");
    tick_wait();
    chk(A_SEC, 8'h1A, "R4");

    // R8 / R9: freeze cancels a pending update and hides the flag
    wr(A_SEC, 8'h05);
    step(); tick_i = 1'b1;
    step(); tick_i = 1'b0; freeze_i = 1'b1;
    chk_flag(1'b0, "R9");
    pulse();
    idle(UIP + 2);
    chk(A_ST, 8'h00, "R9");
    chk(A_SEC, 8'h05, "R8");
    step(); freeze_i = 1'b0;
    idle(UIP + 2);
    chk(A_SEC, 8'h05, "R8");

    // R9: flag visible while pending
    step(); tick_i = 1'b1; rd_addr = A_ST;
    step(); tick_i = 1'b0;
    chk_flag(1'b1, "R9");
    chk(A_ST, 8'h80, "R9");
    idle(UIP + 2);
    chk(A_SEC, 8'h06, "R9");

    // R10: write in the commit cycle wins for its own field
    wr(A_SEC, 8'h10); wr(A_MIN, 8'h20);
    step(); tick_i = 1'b1;
    step(); tick_i = 1'b0;
    for (int i = 0; i < UIP - 1; i++) step();
    wr_en = 1'b1; wr_addr = A_MIN; wr_data = 8'h2D;
    step(); wr_en = 1'b0;
    idle(2);
    chk(A_SEC, 8'h11, "R10"); chk(A_MIN, 8'h2D, "R10");

    // R12: a second strobe while pending is dropped
    step(); tick_i = 1'b1;
    step(); tick_i = 1'b0;
    step(); tick_i = 1'b1;
    step(); tick_i = 1'b0;
    idle(UIP + 3);
    chk(A_SEC, 8'h12, "R12");

    // R10: writes to unmapped offsets are ignored
    wr(4'h1, 8'h55); wr(A_ST, 8'hFF); wr(4'hC, 8'h77);
    chk(4'h1, 8'h00, "R10"); chk(A_ST, 8'h00, "R10"); chk(4'hC, 8'h00, "R10");
    chk(A_SEC, 8'h12, "R10");

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule